// File: doc/BRIEF.md
# Lane-Parallel Float/Integer Converter

This block converts a wide vector operand between IEEE floating point and signed integers, one lane at a time. A 2-bit mode selects one of four conversions. Two take floating point to integer: binary32 to 32-bit, and binary16 to 16-bit. The other two take integer to floating point: 32-bit to binary32, and 16-bit to binary16. The vector is split into independent lanes of the selected element width, and every lane goes through the same conversion.

Float-to-integer conversion truncates toward zero and clamps at the ends of the integer range. NaN inputs do not all map to a single code. A NaN whose sign bit is clear becomes the largest positive integer, and a NaN whose sign bit is set becomes the most negative integer. Integer-to-float conversion rounds to nearest, with ties going to the even result.

The block is a fixed two-stage pipeline and accepts a new operand every cycle. A valid bit travels beside the data, and there is no stall path. Between results the output holds its last value.

Top module: `lane_fpint_cvt`

## Requirements
- R1: A conversion presented with `inValid` high appears on `outData` with `outValid` high exactly two clock cycles later. A new operand may be accepted every cycle. `outValid` is low in every cycle whose operand two cycles earlier was not valid.
- R2: The mode encodes the conversion: 0 is binary32 to signed 32-bit, 1 is signed 32-bit to binary32, 2 is binary16 to signed 16-bit, and 3 is signed 16-bit to binary16. In modes 0 and 2, finite in-range inputs truncate toward zero (for example, 3.75 gives 3 and -3.75 gives -3).
- R3: In modes 0 and 2, a NaN with sign bit 0 gives 0x7FFFFFFF or 0x7FFF, and a NaN with sign bit 1 gives 0x80000000 or 0x8000, whatever its payload.
- R4: In modes 0 and 2, infinities and finite values whose truncated magnitude lies outside the signed range saturate by sign to the same maximum or minimum codes as R3. Exactly -2^31 and -2^15 convert without loss.
- R5: In modes 0 and 2, zero of either sign, denormals, and any magnitude below 1 convert to integer 0.
- R6: In modes 1 and 3, every integer that fits exactly in the target significand converts exactly. Integer 0 gives +0.0, and the result's sign bit equals the integer's sign.
- R7: In modes 1 and 3, inexact integers round to nearest, with ties to even. A carry out of the significand increments the exponent (for example, 0x7FFFFFFF gives 0x4F000000 and 32767 gives 0x7800).
- R8: Lane k of the element width W occupies bits [W*k +: W] of both `inData` and `outData`. Each output lane depends only on the input lane with the same index.
- R9: While reset is asserted, `outValid` and `outData` are 0.
- R10: `outData` holds its previous value in every cycle where `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand on `inData` is valid this cycle |
| inMode | input | 2 | Conversion select (encoding in R2) |
| inData | input | DATA_W | Operand vector; DATA_W is a multiple of 32 |
| outValid | output | 1 | `outData` carries a new result |
| outData | output | DATA_W | Result vector |

## Verification
The bench builds the block with DATA_W = 96 instead of the default 64. That gives three 32-bit slices and six 16-bit lanes. The odd slice count exercises lane ordering across more than one pair of slices, and it shows that the per-slice generate structure scales beyond its default. Directed vectors place different corner cases in neighbouring lanes of the same operand, and a seeded random stream mixes all four modes with idle gaps and back-to-back issue.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  typedef enum logic [1:0] {
    MODE_F32_TO_I32 = 2'd0,
    MODE_I32_TO_F32 = 2'd1,
    MODE_F16_TO_I16 = 2'd2,
    MODE_I16_TO_F16 = 2'd3
  } cvtMode_e;

  typedef struct packed {
    logic     capture;
    logic     commit;
    cvtMode_e mode;
  } cvtStrobe_t;

  // binary32 -> int32, toward zero, sign-directed saturation for NaN/inf/range
  function automatic logic [31:0] f32ToInt(input logic [31:0] f);
    logic [7:0]  ex;
    logic [7:0]  e;
    logic [31:0] mag;
    ex = f[30:23];
    if (ex >= 8'd158) return f[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    if (ex < 8'd127) return 32'd0;
    e   = ex - 8'd127;
    mag = {8'd0, 1'b1, f[22:0]};
    if (e >= 8'd23) mag = mag << (e - 8'd23);
    else            mag = mag >> (8'd23 - e);
    return f[31] ? (~mag + 32'd1) : mag;
  endfunction

  // binary16 -> int16
  function automatic logic [15:0] f16ToInt(input logic [15:0] f);
    logic [4:0]  ex;
    logic [4:0]  e;
    logic [15:0] mag;
    ex = f[14:10];
    if (ex >= 5'd30) return f[15] ? 16'h8000 : 16'h7FFF;
    if (ex < 5'd15) return 16'd0;
    e   = ex - 5'd15;
    mag = {5'd0, 1'b1, f[9:0]};
    if (e >= 5'd10) mag = mag << (e - 5'd10);
    else            mag = mag >> (5'd10 - e);
    return f[15] ? (~mag + 16'd1) : mag;
  endfunction

  // int32 -> binary32, round to nearest even
  function automatic logic [31:0] int32ToF32(input logic [31:0] v);
    logic [31:0] mag;
    logic [31:0] norm;
    logic [4:0]  lead;
    logic [30:0] body;
    logic        up;
    if (v == 32'd0) return 32'd0;
    mag  = v[31] ? (~v + 32'd1) : v;
    lead = 5'd0;
    for (int i = 0; i < 32; i++) if (mag[i]) lead = 5'(i);
    norm = mag << (5'd31 - lead);
    up   = norm[7] & ((|norm[6:0]) | norm[8]);
    body = {8'd127 + {3'd0, lead}, norm[30:8]} + {30'd0, up};
    return {v[31], body};
  endfunction

  // int16 -> binary16, round to nearest even
  function automatic logic [15:0] int16ToF16(input logic [15:0] v);
    logic [15:0] mag;
    logic [15:0] norm;
    logic [3:0]  lead;
    logic [14:0] body;
    logic        up;
    if (v == 16'd0) return 16'd0;
    mag  = v[15] ? (~v + 16'd1) : v;
    lead = 4'd0;
    for (int i = 0; i < 16; i++) if (mag[i]) lead = 4'(i);
    norm = mag << (4'd15 - lead);
    up   = norm[4] & ((|norm[3:0]) | norm[5]);
    body = {5'd15 + {1'b0, lead}, norm[14:5]} + {14'd0, up};
    return {v[15], body};
  endfunction

endpackage

// File: rtl/cvt_ctrl.sv
module cvt_ctrl
  import cvt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inMode,
  output cvtStrobe_t stb,
  output logic       outValid
);
  logic     validS1;
  logic     validS2;
  cvtMode_e modeS1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validS1 <= 1'b0;
      validS2 <= 1'b0;
      modeS1  <= MODE_F32_TO_I32;
    end else begin
      validS1 <= inValid;
      validS2 <= validS1;
      if (inValid) modeS1 <= cvtMode_e'(inMode);
    end
  end

  always_comb begin
    stb.capture = inValid;
    stb.commit  = validS1;
    stb.mode    = modeS1;
  end

  assign outValid = validS2;
endmodule

// File: rtl/cvt_datapath.sv
module cvt_datapath
  import cvt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  cvtStrobe_t        stb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);
  localparam int SLICES = DATA_W / 32;

  logic [DATA_W-1:0] opndS1;
  logic [DATA_W-1:0] resNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            opndS1 <= '0;
    else if (stb.capture) opndS1 <= inData;
  end

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    logic [31:0] sliceIn;
    logic [31:0] sliceOut;
    assign sliceIn = opndS1[32*k +: 32];
    always_comb begin
      case (stb.mode)
        MODE_F32_TO_I32: sliceOut = f32ToInt(sliceIn);
        MODE_I32_TO_F32: sliceOut = int32ToF32(sliceIn);
        MODE_F16_TO_I16: sliceOut = {f16ToInt(sliceIn[31:16]), f16ToInt(sliceIn[15:0])};
        default:         sliceOut = {int16ToF16(sliceIn[31:16]), int16ToF16(sliceIn[15:0])};
      endcase
    end
    assign resNext[32*k +: 32] = sliceOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           outData <= '0;
    else if (stb.commit) outData <= resNext;
  end
endmodule

// File: rtl/lane_fpint_cvt.sv
module lane_fpint_cvt
  import cvt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inMode,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  cvtStrobe_t stb;

  cvt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inMode   (inMode),
    .stb      (stb),
    .outValid (outValid)
  );

  cvt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inData  (inData),
    .outData (outData)
  );
endmodule

// File: rtl/lane_fpint_cvt_chk.sv
module lane_fpint_cvt_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        inMode,
  input logic [DATA_W-1:0] inData,
  input logic              outValid,
  input logic [DATA_W-1:0] outData
);
  localparam int SLICES = DATA_W / 32;
  localparam int HALVES = DATA_W / 16;

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= 2'd0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  // R1: result valid exactly two cycles after the operand
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> (outValid == $past(inValid, 2)));

  // R10: no change of the result while not valid
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !outValid) |-> $stable(outData));

  // R9: reset state
  always @(posedge clk)
    if (!rstN) p_reset_r9: assert (outValid == 1'b0 && outData == '0);

  for (genvar k = 0; k < SLICES; k++) begin : g_w
    // R3: binary32 NaN picks the end given by its sign
    p_nan_w_r3: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst == 2'd2 && $past(inValid, 2) && $past(inMode, 2) == 2'd0 &&
       $past(inData[32*k+23 +: 8], 2) == 8'hFF && $past(inData[32*k +: 23], 2) != 23'd0)
      |-> (outData[32*k +: 32] == ($past(inData[32*k+31], 2) ? 32'h8000_0000 : 32'h7FFF_FFFF)));
    // R5: zero and denormal binary32 give 0
    p_zero_w_r5: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst == 2'd2 && $past(inValid, 2) && $past(inMode, 2) == 2'd0 &&
       $past(inData[32*k+23 +: 8], 2) == 8'h00)
      |-> (outData[32*k +: 32] == 32'd0));
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_h
    // R3: binary16 NaN picks the end given by its sign
    p_nan_h_r3: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst == 2'd2 && $past(inValid, 2) && $past(inMode, 2) == 2'd2 &&
       $past(inData[16*h+10 +: 5], 2) == 5'h1F && $past(inData[16*h +: 10], 2) != 10'd0)
      |-> (outData[16*h +: 16] == ($past(inData[16*h+15], 2) ? 16'h8000 : 16'h7FFF)));
  end
endmodule

bind lane_fpint_cvt lane_fpint_cvt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inMode   (inMode),
  .inData   (inData),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/tb_lane_fpint_cvt.sv
`timescale 1ns/1ps
module tb_lane_fpint_cvt;
  localparam int DW = 96;
  localparam int SL = DW / 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [1:0]    inMode = 2'd0;
  logic [DW-1:0] inData = '0;
  logic          outValid;
  logic [DW-1:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  bit            h0v = 1'b0, h1v = 1'b0;
  logic [DW-1:0] h0e = '0, h1e = '0, lastExp = '0;
  string         h0t = "", h1t = "";

  always #4 clk = ~clk;

  lane_fpint_cvt #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refF2I(input logic [31:0] b, input bit half);
    int eb = half ? 5 : 8;
    int mb = half ? 10 : 23;
    int ib = half ? 16 : 32;
    int bias = (1 << (eb - 1)) - 1;
    longint ex, man, mag, lo, hi, val;
    int e;
    bit s;
    ex  = longint'((b >> mb) & ((32'd1 << eb) - 1));
    man = longint'(b & ((32'd1 << mb) - 1));
    s   = b[eb + mb];
    hi  = (longint'(1) << (ib - 1)) - 1;
    lo  = -(longint'(1) << (ib - 1));
    if (ex == longint'((1 << eb) - 1)) val = s ? lo : hi;
    else if (ex < longint'(bias)) val = 0;
    else begin
      e = int'(ex) - bias;
      if (e > 40) val = s ? lo : hi;
      else begin
        mag = (longint'(1) << mb) | man;
        if (e >= mb) mag = mag << (e - mb);
        else         mag = mag >> (mb - e);
        val = s ? -mag : mag;
        if (val > hi) val = hi;
        if (val < lo) val = lo;
      end
    end
    return half ? {16'h0, val[15:0]} : val[31:0];
  endfunction

  function automatic logic [31:0] refI2F(input logic [31:0] b, input bit half);
    int eb = half ? 5 : 8;
    int mb = half ? 10 : 23;
    int bias = (1 << (eb - 1)) - 1;
    longint v, mag, q, r, hv, res;
    int p, sh;
    bit s;
    v = half ? longint'($signed(b[15:0])) : longint'($signed(b));
    if (v == 0) return 32'd0;
    s = (v < 0);
    mag = s ? -v : v;
    p = 0;
    while ((mag >> (p + 1)) != 0) p++;
    if (p <= mb) q = mag << (mb - p);
    else begin
      sh = p - mb;
      q  = mag >> sh;
      r  = mag - (q << sh);
      hv = longint'(1) << (sh - 1);
      if (r > hv || (r == hv && q[0])) q++;
      if (q == (longint'(1) << (mb + 1))) begin q = q >> 1; p++; end
    end
    res = (longint'(s) << (eb + mb)) | (longint'(p + bias) << mb) | (q & ((longint'(1) << mb) - 1));
    return res[31:0];
  endfunction

  function automatic logic [DW-1:0] refVec(input logic [1:0] m, input logic [DW-1:0] d);
    logic [DW-1:0] o;
    logic [31:0] c, lo, hi;
    for (int k = 0; k < SL; k++) begin
      c = d[32*k +: 32];
      case (m)
        2'd0: o[32*k +: 32] = refF2I(c, 1'b0);
        2'd1: o[32*k +: 32] = refI2F(c, 1'b0);
        2'd2: begin
          lo = refF2I({16'h0, c[15:0]}, 1'b1);
          hi = refF2I({16'h0, c[31:16]}, 1'b1);
          o[32*k +: 32] = {hi[15:0], lo[15:0]};
        end
        default: begin
          lo = refI2F({16'h0, c[15:0]}, 1'b1);
          hi = refI2F({16'h0, c[31:16]}, 1'b1);
          o[32*k +: 32] = {hi[15:0], lo[15:0]};
        end
      endcase
    end
    return o;
  endfunction

  // One cycle: check the result due now, then present a new operand
  task automatic step(input bit v, input logic [1:0] m, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    if (h1v) begin
      chk(outValid === 1'b1, "R1 valid", {{(DW-1){1'b0}}, outValid}, 1);
      chk(outData === h1e, h1t, outData, h1e);
      lastExp = h1e;
    end else begin
      chk(outValid === 1'b0, "R1 idle", {{(DW-1){1'b0}}, outValid}, 0);
      chk(outData === lastExp, "R10 hold", outData, lastExp);
    end
    h1v = h0v; h1e = h0e; h1t = h0t;
    h0v = v;   h0e = refVec(m, d); h0t = tag;
    inValid = v;
    inMode  = m;
    inData  = d;
  endtask

  function automatic logic [DW-1:0] w3(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    return {c, b, a};
  endfunction

  function automatic logic [DW-1:0] h6(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                                       input logic [15:0] d, input logic [15:0] e, input logic [15:0] f);
    return {f, e, d, c, b, a};
  endfunction

  function automatic logic [DW-1:0] rndVec(input logic [1:0] m);
    logic [DW-1:0] d;
    for (int k = 0; k < SL; k++) begin
      d[32*k +: 32] = $urandom;
      if (m == 2'd0 && $urandom_range(1, 0) == 1) d[32*k+23 +: 8] = 8'(110 + $urandom_range(50, 0));
      if (m == 2'd2 && $urandom_range(1, 0) == 1) begin
        d[32*k+10 +: 5] = 5'(10 + $urandom_range(21, 0));
        d[32*k+26 +: 5] = 5'(10 + $urandom_range(21, 0));
      end
    end
    return d;
  endfunction

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [1:0] m;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk(outValid === 1'b0, "R9 valid", {{(DW-1){1'b0}}, outValid}, 0);
    chk(outData === '0, "R9 data", outData, '0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: truncation toward zero
    step(1, 2'd0, w3(32'h4070_0000, 32'hC070_0000, 32'h4E6E_6B28), "R2 f32 trunc");
    step(1, 2'd2, h6(16'h4100, 16'hC7E6, 16'h3BFF, 16'hBBFF, 16'h5A40, 16'hDA40), "R2 f16 trunc");
    // R3: NaN by sign
    step(1, 2'd0, w3(32'h7FC0_0000, 32'hFFC0_0000, 32'hFF80_0001), "R3 f32 NaN");
    step(1, 2'd2, h6(16'h7E00, 16'hFE00, 16'h7C01, 16'hFC01, 16'h7FFF, 16'hFFFF), "R3 f16 NaN");
    step(0, 2'd0, '0, "");
    step(0, 2'd0, '0, "");
    // R4: saturation
    step(1, 2'd0, w3(32'h7F80_0000, 32'hFF80_0000, 32'h4F32_D05E), "R4 f32 inf/range");
    step(1, 2'd0, w3(32'hCF00_0000, 32'h4F00_0000, 32'hCF32_D05E), "R4 f32 edge");
    step(1, 2'd2, h6(16'h7C00, 16'hFC00, 16'h7BFF, 16'hF800, 16'h7800, 16'hFBFF), "R4 f16 inf/range");
    // R5: zero and denormals
    step(1, 2'd0, w3(32'h0000_0000, 32'h8000_0000, 32'h0000_0001), "R5 f32 zero");
    step(1, 2'd2, h6(16'h0000, 16'h8000, 16'h03FF, 16'h8001, 16'h3800, 16'hB800), "R5 f16 zero");
    step(0, 2'd1, '1, "");
    // R6: exact integer conversions
    step(1, 2'd1, w3(32'd1, 32'hFFFF_FFFF, 32'd16777216), "R6 i32 exact");
    step(1, 2'd3, h6(16'd1, 16'hFFFF, 16'h8000, 16'd2048, 16'd1000, 16'd0), "R6 i16 exact");
    step(1, 2'd1, w3(32'd0, 32'h8000_0000, 32'd12345), "R6 i32 zero/min");
    // R7: rounding, ties to even, carry into exponent
    step(1, 2'd1, w3(32'd16777217, 32'd16777219, 32'h7FFF_FFFF), "R7 i32 round");
    step(1, 2'd3, h6(16'd2049, 16'd2051, 16'd32767, 16'hF7FD, 16'd4097, 16'd2050), "R7 i16 round");
    // R8: mixed neighbours in one operand
    step(1, 2'd2, h6(16'h7E00, 16'h4100, 16'hFC00, 16'h0001, 16'hC7E6, 16'hFE00), "R8 lanes f16");
    step(1, 2'd0, w3(32'hFFC0_0000, 32'h4070_0000, 32'h7F80_0000), "R8 lanes f32");
    step(0, 2'd3, '1, "");
    step(0, 2'd3, '1, "");

    // R8: seeded random stream, all modes, idle gaps
    for (int i = 0; i < 4000; i++) begin
      m = 2'($urandom_range(3, 0));
      if ($urandom_range(4, 0) == 0) step(0, m, rndVec(m), "");
      else                          step(1, m, rndVec(m), "R8 random");
    end
    step(0, 2'd0, '0, "");
    step(0, 2'd0, '0, "");
    step(0, 2'd0, '0, "");

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule